// File: doc/BRIEF.md
# Dual-Compare 8-bit Waveform Timer

This block is an 8-bit up/down counter with two compare channels, A and B. It produces waveforms and raises event flags. A count-source selector advances the counter. The source can be nothing, every clock, one of four externally generated prescaler strobes, or a chosen edge of an external pin after that pin is synchronised. Four waveform modes are available: free-running, clear-on-compare with an adjustable period, single-slope fast PWM and dual-slope phase-correct PWM.

Software reaches the block through one write port. Each write carries a 3-bit address and a data byte. The port sets the mode, the count source, both compare values and the counter itself. The same port clears the flags by writing ones. The current count, both waveform outputs and the three flags are always visible at the outputs.

In both PWM modes, compare values pass through a holding register. They take effect only at the top of the count, so the duty cycle never changes in the middle of a period.

Top module: `pwm_timer8`

## Requirements
- R1: After reset the count is 0, both waveform outputs are 0, all flags are 0, the source is "stopped", the mode is free-running and both channel output modes are "off".
- R2: The count-source code (address 1, bits 2:0) works as follows: 0 = stopped, 1 = every clock, 2..5 = pre_tick[0..3], 6 = falling edge of ext_pin, 7 = rising edge of ext_pin. The pin passes through two flip-flops before its edge is detected. A pin change made before clock edge k advances the counter at edge k+2.
- R3: In free-running mode (mode 0) the counter counts up and wraps from 255 to 0. The overflow flag (flags bit 0) is set on the step taken from 255.
- R4: In clear-on-compare mode (mode 1) the top value is the active compare A value. The step taken from a count equal to that value goes to 0. Overflow is set only on a step taken from 255.
- R5: In fast PWM mode (mode 2) the counter counts up from 0 to the top value and then returns to 0. The step taken from the top value sets overflow. The top value is 255 when control bit 2 is 0, and the active compare A value when it is 1.
- R6: In phase-correct mode (mode 3) the counter counts up to the top value, turns and counts down to 0. It then turns up again. The overflow flag is set on the step taken from 0 while counting down. The top value is chosen as in R5.
- R7: A count step taken from a value equal to a channel's active compare value sets that channel's flag (bit 1 for A, bit 2 for B). The first step after a counter write never matches. A cycle with a counter write does not count.
- R8: In both PWM modes a compare write goes to a holding register. The holding register is copied to the active value on the step taken from the top value (fast PWM), or on the step where counting up reaches the top value (phase-correct). In modes 0 and 1 a compare write takes effect at once.
- R9: A channel's output mode is a 2-bit field: 0 = output held at 0, 1 = toggle on match, 2 = non-inverting, 3 = inverting. In modes 0 and 1, non-inverting clears the output on a match. In fast PWM, non-inverting sets the output on the step from the top value, and otherwise clears it on a match. In phase-correct mode, non-inverting clears the output on a match while counting up and sets it on a match while counting down. Inverting does the opposite in each case.
- R10: Writing address 5 clears every flag whose data bit (0, 1 or 2) is 1. A flag event in the same cycle wins over the clear.
- R11: The register map is: address 0 holds the control register, with mode in bits 1:0, the top select in bit 2, the channel A output mode in bits 5:4 and the channel B output mode in bits 7:6. Address 1 holds the count source. Address 2 holds compare A and address 3 holds compare B. Address 4 loads the counter. Address 5 clears flags. Each write takes effect at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Write data |
| pre_tick | input | 4 | Prescaler strobes, one cycle wide each |
| ext_pin | input | 1 | External count pin (asynchronous) |
| count | output | 8 | Current counter value |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| flags | output | 3 | {match B, match A, overflow} |

## Verification
A count step, a compare match, a flag change and a waveform change caused by a step all show up one clock edge after the edge where the step occurred. A register write also takes effect one edge later. The one exception is an external pin change, which reaches the count two edges later than a prescaler strobe would, because of the synchroniser. A behavioural reference model updates on every rising edge from the same inputs the design sees. It is compared with count, both waveforms and the flags at every falling edge, so each of these latencies is checked exactly and never inside a tolerance window.

// File: rtl/pwm_timer8_pkg.sv
package pwm_timer8_pkg;

    localparam int CSEL_W = 3;
    localparam int PRE_N  = 4;
    localparam int NFLAG  = 3;
    localparam int NCH    = 2;
    localparam int AW     = 3;

    localparam logic [AW-1:0] ADDR_CTRL = 3'd0;
    localparam logic [AW-1:0] ADDR_CSEL = 3'd1;
    localparam logic [AW-1:0] ADDR_CMPA = 3'd2;
    localparam logic [AW-1:0] ADDR_CMPB = 3'd3;
    localparam logic [AW-1:0] ADDR_CNT  = 3'd4;
    localparam logic [AW-1:0] ADDR_FLAG = 3'd5;

    typedef enum logic [1:0] {
        WM_FREE  = 2'd0,
        WM_CTC   = 2'd1,
        WM_FAST  = 2'd2,
        WM_PHASE = 2'd3
    } wave_mode_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'd0,
        OM_TOGGLE = 2'd1,
        OM_NONINV = 2'd2,
        OM_INV    = 2'd3
    } out_mode_e;

endpackage

// File: rtl/pwm_timer8_tick_sel.sv
module pwm_timer8_tick_sel
    import pwm_timer8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CSEL_W-1:0] csel,
    input  logic [PRE_N-1:0]  pre_tick,
    input  logic              ext_pin,
    output logic              tick
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic prev;
    } sync_s;

    sync_s sy_d, sy_q;
    logic  rise, fall;

    always_comb begin
        sy_d      = sy_q;
        sy_d.s1   = ext_pin;
        sy_d.s2   = sy_q.s1;
        sy_d.prev = sy_q.s2;

        rise = sy_q.s2 & ~sy_q.prev;
        fall = ~sy_q.s2 & sy_q.prev;

        tick = 1'b0;
        if (csel == CSEL_W'(1)) tick = 1'b1;
        if (csel == CSEL_W'(6)) tick = fall;
        if (csel == CSEL_W'(7)) tick = rise;
        for (int i = 0; i < PRE_N; i++) begin
            if (csel == CSEL_W'(i + 2)) tick = pre_tick[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    // R2: a detected pin edge is a single-cycle strobe
    p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
    p_fall_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);

endmodule

// File: rtl/pwm_timer8_count.sv
module pwm_timer8_count
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  wave_mode_e       mode,
    input  logic [CNT_W-1:0] top_val,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] cnt,
    output logic             down,
    output logic             block,
    output logic             step,
    output logic             tov_evt,
    output logic             upd_evt,
    output logic             wrap_evt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             down;
        logic             block;
    } cnt_s;

    cnt_s c_d, c_q;

    always_comb begin
        c_d      = c_q;
        tov_evt  = 1'b0;
        upd_evt  = 1'b0;
        wrap_evt = 1'b0;
        step     = tick & ~cnt_wr;

        if (cnt_wr) begin
            c_d.cnt   = wr_val;
            c_d.block = 1'b1;
        end else if (tick) begin
            c_d.block = 1'b0;
            unique case (mode)
                WM_FREE: begin
                    c_d.cnt = c_q.cnt + ONE;
                    tov_evt = (c_q.cnt == CNT_MAX);
                end
                WM_CTC: begin
                    c_d.cnt = (c_q.cnt == top_val) ? '0 : c_q.cnt + ONE;
                    tov_evt = (c_q.cnt == CNT_MAX);
                end
                WM_FAST: begin
                    if (c_q.cnt == top_val) begin
                        c_d.cnt  = '0;
                        tov_evt  = 1'b1;
                        upd_evt  = 1'b1;
                        wrap_evt = 1'b1;
                    end else begin
                        c_d.cnt = c_q.cnt + ONE;
                    end
                end
                WM_PHASE: begin
                    if (!c_q.down) begin
                        if (c_q.cnt >= top_val) begin
                            c_d.down = 1'b1;
                            upd_evt  = 1'b1;
                            c_d.cnt  = (c_q.cnt == '0) ? '0 : c_q.cnt - ONE;
                        end else begin
                            c_d.cnt = c_q.cnt + ONE;
                        end
                    end else if (c_q.cnt == '0) begin
                        c_d.down = 1'b0;
                        tov_evt  = 1'b1;
                        c_d.cnt  = (top_val == '0) ? '0 : ONE;
                    end else begin
                        c_d.cnt = c_q.cnt - ONE;
                    end
                end
                default: c_d.cnt = c_q.cnt;
            endcase
        end

        if (mode != WM_PHASE) c_d.down = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign cnt   = c_q.cnt;
    assign down  = c_q.down;
    assign block = c_q.block;

    // R4: a step taken at TOP in clear-on-compare mode lands on zero
    p_ctc_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == WM_CTC && cnt == top_val) |=> (cnt == '0));
    // R6: counting down in phase-correct mode decrements by one
    p_pc_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == WM_PHASE && down && cnt != '0) |=> (cnt == $past(cnt) - ONE));
    // R11: a counter write loads the value and arms the match block
    p_cnt_load_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(wr_val) && block));

endmodule

// File: rtl/pwm_timer8_cmp.sv
module pwm_timer8_cmp
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wave_mode_e       mode,
    input  out_mode_e        out_mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             step,
    input  logic             block,
    input  logic             down,
    input  logic             upd_evt,
    input  logic             wrap_evt,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wr_val,
    output logic [CNT_W-1:0] active,
    output logic             match,
    output logic             wave
);

    typedef struct packed {
        logic [CNT_W-1:0] hold;
        logic [CNT_W-1:0] act;
        logic             wave;
    } cmp_s;

    cmp_s k_d, k_q;
    logic pwm;
    logic lvl;

    always_comb begin
        k_d   = k_q;
        pwm   = (mode == WM_FAST) || (mode == WM_PHASE);
        match = step & ~block & (cnt == k_q.act);
        lvl   = (out_mode == OM_INV);

        if (cmp_wr) begin
            k_d.hold = wr_val;
            if (!pwm) k_d.act = wr_val;
        end
        if (pwm && upd_evt) k_d.act = k_q.hold;

        unique case (out_mode)
            OM_OFF:    k_d.wave = 1'b0;
            OM_TOGGLE: if (match) k_d.wave = ~k_q.wave;
            default: begin
                unique case (mode)
                    WM_FAST: begin
                        if (wrap_evt)   k_d.wave = ~lvl;
                        else if (match) k_d.wave = lvl;
                    end
                    WM_PHASE: if (match) k_d.wave = down ? ~lvl : lvl;
                    default:  if (match) k_d.wave = lvl;
                endcase
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) k_q <= '0;
        else        k_q <= k_d;
    end

    assign active = k_q.act;
    assign wave   = k_q.wave;

    // R8: in PWM modes the active compare only moves at the update point
    p_buf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !upd_evt) |=> $stable(active));
    // R9: output mode "off" holds the pin low
    p_off_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_mode == OM_OFF) |=> !wave);

endmodule

// File: rtl/pwm_timer8.sv
module pwm_timer8
    import pwm_timer8_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [PRE_N-1:0] pre_tick,
    input  logic             ext_pin,
    output logic [CNT_W-1:0] count,
    output logic             wave_a,
    output logic             wave_b,
    output logic [NFLAG-1:0] flags
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    typedef struct packed {
        wave_mode_e        mode;
        logic              top_a;
        out_mode_e         om_a;
        out_mode_e         om_b;
        logic [CSEL_W-1:0] csel;
        logic [NFLAG-1:0]  flg;
    } regs_s;

    regs_s r_d, r_q;

    logic             tick, step, down, block;
    logic             tov_evt, upd_evt, wrap_evt, cnt_wr;
    logic [CNT_W-1:0] cnt, top_val;
    logic [CNT_W-1:0] act   [NCH];
    logic [NCH-1:0]   match;
    logic [NCH-1:0]   wave;
    out_mode_e        om    [NCH];

    always_comb begin
        r_d    = r_q;
        cnt_wr = wr_en && (wr_addr == ADDR_CNT);
        om[0]  = r_q.om_a;
        om[1]  = r_q.om_b;

        if ((r_q.mode == WM_CTC) ||
            (((r_q.mode == WM_FAST) || (r_q.mode == WM_PHASE)) && r_q.top_a))
            top_val = act[0];
        else
            top_val = CNT_MAX;

        if (wr_en && wr_addr == ADDR_CTRL) begin
            r_d.mode  = wave_mode_e'(wr_data[1:0]);
            r_d.top_a = wr_data[2];
            r_d.om_a  = out_mode_e'(wr_data[5:4]);
            r_d.om_b  = out_mode_e'(wr_data[7:6]);
        end
        if (wr_en && wr_addr == ADDR_CSEL) r_d.csel = wr_data[CSEL_W-1:0];
        if (wr_en && wr_addr == ADDR_FLAG) r_d.flg = r_q.flg & ~wr_data[NFLAG-1:0];
        r_d.flg = r_d.flg | {match[1], match[0], tov_evt};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    pwm_timer8_tick_sel u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .csel     (r_q.csel),
        .pre_tick (pre_tick),
        .ext_pin  (ext_pin),
        .tick     (tick)
    );

    pwm_timer8_count #(.CNT_W(CNT_W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .mode     (r_q.mode),
        .top_val  (top_val),
        .cnt_wr   (cnt_wr),
        .wr_val   (wr_data),
        .cnt      (cnt),
        .down     (down),
        .block    (block),
        .step     (step),
        .tov_evt  (tov_evt),
        .upd_evt  (upd_evt),
        .wrap_evt (wrap_evt)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwm_timer8_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode     (r_q.mode),
            .out_mode (om[g]),
            .cnt      (cnt),
            .step     (step),
            .block    (block),
            .down     (down),
            .upd_evt  (upd_evt),
            .wrap_evt (wrap_evt),
            .cmp_wr   (wr_en && (wr_addr == ADDR_CMPA + AW'(g))),
            .wr_val   (wr_data),
            .active   (act[g]),
            .match    (match[g]),
            .wave     (wave[g])
        );
    end

    assign count  = cnt;
    assign wave_a = wave[0];
    assign wave_b = wave[1];
    assign flags  = r_q.flg;

    // R3: an overflow event is visible in the flags on the next cycle
    p_tov_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tov_evt |=> flags[0]);
    // R7: a channel match raises its flag
    p_match_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        match[0] |=> flags[1]);
    // R7: the step after a counter write cannot match
    p_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (match == '0));
    // R10: write-one clears overflow when no new event arrives
    p_flag_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_FLAG && wr_data[0] && !tov_evt) |=> !flags[0]);

endmodule

// File: tb/pwm_timer8_tb_top.sv
module pwm_timer8_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] pre_tick = '0;
    logic       ext_pin = 1'b0;
    logic [7:0] count;
    logic       wave_a, wave_b;
    logic [2:0] flags;

    int    n_chk = 0;
    int    n_fail = 0;
    int    cyc = 0;
    bit    done = 1'b0;
    string cur_req = "R1 reset state";

    // reference model state
    int m_cnt, m_down, m_block, m_flags, m_mode, m_topa, m_csel;
    int m_s1, m_s2, m_pv;
    int m_buf [2];
    int m_act [2];
    int m_wave[2];
    int m_om  [2];
    // per-edge temporaries
    int t_tk, t_cw, t_step, t_pwm, t_top, t_tov, t_upd, t_wrap, t_lvl;
    int t_cnt, t_down, t_block, t_flags;
    int t_mt  [2];
    int t_buf [2];
    int t_act [2];
    int t_wave[2];

    pwm_timer8 dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .pre_tick (pre_tick),
        .ext_pin  (ext_pin),
        .count    (count),
        .wave_a   (wave_a),
        .wave_b   (wave_b),
        .flags    (flags)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic model_reset();
        m_cnt = 0; m_down = 0; m_block = 0; m_flags = 0; m_mode = 0;
        m_topa = 0; m_csel = 0; m_s1 = 0; m_s2 = 0; m_pv = 0;
        for (int i = 0; i < 2; i++) begin
            m_buf[i] = 0; m_act[i] = 0; m_wave[i] = 0; m_om[i] = 0;
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            // count source (R2)
            case (m_csel)
                0: t_tk = 0;
                1: t_tk = 1;
                6: t_tk = (m_s2 == 0 && m_pv == 1) ? 1 : 0;
                7: t_tk = (m_s2 == 1 && m_pv == 0) ? 1 : 0;
                default: t_tk = int'(pre_tick[m_csel - 2]);
            endcase
            t_cw   = (wr_en && wr_addr == 3'd4) ? 1 : 0;
            t_step = (t_tk && !t_cw) ? 1 : 0;
            t_pwm  = (m_mode >= 2) ? 1 : 0;
            t_top  = (m_mode == 1 || (t_pwm && m_topa)) ? m_act[0] : 255;
            for (int i = 0; i < 2; i++)
                t_mt[i] = (t_step && !m_block && m_cnt == m_act[i]) ? 1 : 0;
            t_tov = 0; t_upd = 0; t_wrap = 0;
            t_cnt = m_cnt; t_down = m_down; t_block = m_block;
            if (t_cw) begin
                t_cnt = int'(wr_data); t_block = 1;
            end else if (t_tk) begin
                t_block = 0;
                case (m_mode)
                    0: begin t_cnt = (m_cnt + 1) % 256; t_tov = (m_cnt == 255); end
                    1: begin t_cnt = (m_cnt == t_top) ? 0 : (m_cnt + 1) % 256; t_tov = (m_cnt == 255); end
                    2: begin
                        if (m_cnt == t_top) begin t_cnt = 0; t_tov = 1; t_upd = 1; t_wrap = 1; end
                        else t_cnt = (m_cnt + 1) % 256;
                    end
                    default: begin
                        if (!m_down) begin
                            if (m_cnt >= t_top) begin
                                t_down = 1; t_upd = 1; t_cnt = (m_cnt == 0) ? 0 : m_cnt - 1;
                            end else t_cnt = m_cnt + 1;
                        end else if (m_cnt == 0) begin
                            t_down = 0; t_tov = 1; t_cnt = (t_top == 0) ? 0 : 1;
                        end else t_cnt = m_cnt - 1;
                    end
                endcase
            end
            if (m_mode != 3) t_down = 0;
            // channels (R8, R9)
            for (int i = 0; i < 2; i++) begin
                t_buf[i] = m_buf[i]; t_act[i] = m_act[i]; t_wave[i] = m_wave[i];
                if (wr_en && wr_addr == 3'(2 + i)) begin
                    t_buf[i] = int'(wr_data);
                    if (!t_pwm) t_act[i] = int'(wr_data);
                end
                if (t_pwm && t_upd) t_act[i] = m_buf[i];
                t_lvl = (m_om[i] == 3) ? 1 : 0;
                if (m_om[i] == 0) t_wave[i] = 0;
                else if (m_om[i] == 1) begin
                    if (t_mt[i]) t_wave[i] = 1 - m_wave[i];
                end else if (m_mode == 2) begin
                    if (t_wrap) t_wave[i] = 1 - t_lvl;
                    else if (t_mt[i]) t_wave[i] = t_lvl;
                end else if (m_mode == 3) begin
                    if (t_mt[i]) t_wave[i] = m_down ? 1 - t_lvl : t_lvl;
                end else if (t_mt[i]) t_wave[i] = t_lvl;
            end
            // flags (R10)
            t_flags = m_flags;
            if (wr_en && wr_addr == 3'd5) t_flags = t_flags & ~int'(wr_data[2:0]);
            t_flags = t_flags | t_tov | (t_mt[0] << 1) | (t_mt[1] << 2);
            // control (R11)
            if (wr_en && wr_addr == 3'd0) begin
                m_mode = int'(wr_data[1:0]); m_topa = int'(wr_data[2]);
                m_om[0] = int'(wr_data[5:4]); m_om[1] = int'(wr_data[7:6]);
            end
            if (wr_en && wr_addr == 3'd1) m_csel = int'(wr_data[2:0]);
            m_pv = m_s2; m_s2 = m_s1; m_s1 = int'(ext_pin);
            m_cnt = t_cnt; m_down = t_down; m_block = t_block; m_flags = t_flags;
            for (int i = 0; i < 2; i++) begin
                m_buf[i] = t_buf[i]; m_act[i] = t_act[i]; m_wave[i] = t_wave[i];
            end
        end
    end

    task automatic chk(input int actual, input int expected, input string what);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, actual, expected);
        end
    endtask

    always @(negedge clk) begin
        if (cyc >= 1 && !done) begin
            chk(int'(count), m_cnt, "count");
            chk(int'(wave_a), m_wave[0], "wave_a");
            chk(int'(wave_b), m_wave[1], "wave_b");
            chk(int'(flags), m_flags, "flags");
        end
    end

    initial begin
        forever begin
            @(negedge clk);
            pre_tick = 4'($urandom);
        end
    end

    initial begin
        forever begin
            repeat (7) @(negedge clk);
            ext_pin = ~ext_pin;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
    end

    initial begin
        // R1: reset values, then idle while stopped
        run(4);
        rst_n = 1'b1;
        run(6);

        // R11 / R3: free-running, channel A toggle, B non-inverting
        cur_req = "R3 free-running overflow";
        wr(3'd2, 8'h40);
        wr(3'd3, 8'h80);
        wr(3'd0, 8'h90);
        wr(3'd1, 8'd1);
        run(600);
        cur_req = "R10 flag clear";
        wr(3'd5, 8'h07);
        run(40);
        wr(3'd5, 8'h02);
        run(300);

        // R4: clear-on-compare with period set by compare A
        cur_req = "R4 clear-on-compare";
        wr(3'd0, 8'h51);
        wr(3'd2, 8'd20);
        wr(3'd3, 8'd7);
        run(200);
        wr(3'd2, 8'd9);
        run(100);

        // R5 / R8 / R9: fast PWM, top 255, A non-inverting, B inverting
        cur_req = "R5 fast PWM top 255";
        wr(3'd0, 8'hE2);
        wr(3'd2, 8'h30);
        run(300);
        cur_req = "R8 buffered compare";
        wr(3'd3, 8'h10);
        run(100);
        wr(3'd3, 8'hF0);
        run(500);
        cur_req = "R5 fast PWM top from compare A";
        wr(3'd2, 8'd50);
        wr(3'd0, 8'hE6);
        run(400);

        // R6: phase-correct, top 255 then top from compare A
        cur_req = "R6 phase-correct top 255";
        wr(3'd0, 8'hE3);
        run(700);
        cur_req = "R6 phase-correct top from compare A";
        wr(3'd2, 8'd60);
        wr(3'd3, 8'd20);
        wr(3'd0, 8'h97);
        run(600);

        // R7: counter write blocks the next match
        cur_req = "R7 match blocking";
        wr(3'd0, 8'h50);
        wr(3'd2, 8'h10);
        wr(3'd3, 8'h11);
        wr(3'd5, 8'h07);
        wr(3'd4, 8'h10);
        run(10);
        wr(3'd4, 8'h0F);
        run(10);

        // R2: count sources
        for (int s = 2; s <= 5; s++) begin
            cur_req = "R2 prescaler strobe";
            wr(3'd1, 8'(s));
            run(150);
        end
        cur_req = "R2 stopped";
        wr(3'd1, 8'd0);
        run(30);
        cur_req = "R2 external rising";
        wr(3'd1, 8'd7);
        run(300);
        cur_req = "R2 external falling";
        wr(3'd1, 8'd6);
        run(300);

        // R11: random register traffic in every mode
        cur_req = "R11 random register access";
        wr(3'd1, 8'd1);
        for (int k = 0; k < 1500; k++) begin
            @(negedge clk);
            if ($urandom_range(0, 3) == 0) begin
                wr_en   = 1'b1;
                wr_addr = 3'($urandom_range(0, 5));
                wr_data = 8'($urandom);
                if (wr_addr == 3'd1) wr_data = 8'($urandom_range(1, 7));
            end else begin
                wr_en = 1'b0;
            end
        end
        wr_en = 1'b0;
        run(20);

        summary();
    end

endmodule